// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Engine

This block is a single-channel engine that walks a linked list of transfer descriptors kept in host memory and turns each one into a command for an external data mover. Software writes the address of the first descriptor into a pointer register pair and launches the chain with one control write. The engine then reads the descriptor words through a simple request/acknowledge read port, issues the described transfer (64-bit bus address, byte count, direction), waits for the mover's completion handshake, and moves on to the descriptor named by the link word.

Chain control lives in the low bits of each descriptor's link word. One bit ends the chain, one asks for an interrupt when that descriptor completes, and one gives the transfer direction. A chain whose last link points back at its own head runs without end until software aborts it. A running total of completed bytes can be read back, and a sticky interrupt flag with a one-cycle interrupt pulse reports completions.

Top module: `sgdma_engine`

## Requirements
- R1: After reset the control word reads done (bit 4) as 1, the interrupt flag (bit 5) as 0, the byte total (register offset 3) as 0, and neither fetch_req nor xfer_valid is asserted.
- R2: A write to the control register (offset 2) with bits 0, 1 and 8 all set, while idle, launches the chain at the pointer {offset 1, offset 0 with bits 4:0 cleared}; the eight words of a descriptor are read at byte offsets 0, 4, ..., 28 in that order: bus address low, bus address high, local, spare, byte count, spare, link low, link high. A fetch request and its address hold until acknowledged.
- R3: Each valid descriptor produces exactly one transfer command with xfer_addr = {word 1, word 0}, xfer_len = word 4 and xfer_to_host = bit 3 of the link-low word; the command holds until xfer_done, and a fetch and a transfer are never outstanding together.
- R4: After a transfer completes without end of chain, the next descriptor is fetched from {link high, link low with bits 4:0 cleared}.
- R5: When a descriptor whose link-low bit 1 is set completes, the engine goes idle and done reads 1; while idle it issues no requests.
- R6: When a descriptor whose link-low bit 2 is set completes, the interrupt flag (control bit 5) is set and irq pulses high for exactly one cycle; writing 1 to control bit 5 clears the flag.
- R7: The byte total (offset 3) adds the byte count of each completed descriptor and is cleared by a launch.
- R8: A launch write while a chain is running is ignored: the running chain continues unchanged and the byte total is not cleared.
- R9: Writing control bit 2 while busy aborts: no further descriptor is fetched after the transfer in progress completes, an abort during a fetch issues no transfer, and done is then set.
- R10: A descriptor whose 64-bit bus address is zero ends the chain without issuing a transfer.
- R11: A chain whose last link points to its head repeats its descriptors in order until aborted.
- R12: A control write lacking any of bits 0, 1 or 8 does not launch the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle; data valid the next cycle |
| reg_addr | input | 2 | Register word offset: 0 pointer low, 1 pointer high, 2 control/status, 3 byte total |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, registered |
| fetch_req | output | 1 | Descriptor word read request, held until acknowledged |
| fetch_addr | output | 64 | Byte address of the requested descriptor word |
| fetch_ack | input | 1 | Read acknowledge, one cycle, with data |
| fetch_data | input | 32 | Descriptor word returned with fetch_ack |
| xfer_valid | output | 1 | Transfer command valid, held until xfer_done |
| xfer_addr | output | 64 | Host bus address of the transfer |
| xfer_len | output | 32 | Transfer length in bytes |
| xfer_to_host | output | 1 | 1 writes toward the host bus, 0 reads from it |
| xfer_done | input | 1 | Transfer completion, one cycle |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest cases to reach from the ports are an abort that lands while a descriptor is still being fetched and an abort against a chain that loops forever. The bench stretches the read latency so that an abort written a few cycles after launch is certain to fall inside the first fetch, and runs a two-descriptor loop until several laps are logged before aborting and checking that at most the transfer already in flight completes. A launch during a running chain is forced by slowing the mover so the chain is certainly busy when the second launch arrives; random chains with mixed flags, latencies and slot orders cover the normal walk.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

  localparam int DESC_WORDS = 8;
  localparam int WORD_W     = 32;

  // link-low control bits
  localparam int LINK_LAST_BIT = 1;
  localparam int LINK_IRQ_BIT  = 2;
  localparam int LINK_DIR_BIT  = 3;

  // control/status bits
  localparam int CS_ENABLE = 0;
  localparam int CS_START  = 1;
  localparam int CS_ABORT  = 2;
  localparam int CS_DONE   = 4;
  localparam int CS_IRQF   = 5;
  localparam int CS_SGMODE = 8;

  // word slots inside a descriptor
  localparam int W_BUS_LO  = 0;
  localparam int W_BUS_HI  = 1;
  localparam int W_COUNT   = 4;
  localparam int W_LINK_LO = 6;
  localparam int W_LINK_HI = 7;

  typedef struct packed {
    logic [63:0] bus_addr;
    logic [31:0] count;
    logic        last;
    logic        irq;
    logic        to_host;
    logic [63:0] next_ptr;
  } desc_t;

  function automatic logic [63:0] align_ptr(input logic [31:0] hi, input logic [31:0] lo);
    return {hi, lo[31:5], 5'b00000};
  endfunction

  function automatic logic [31:0] pick_word(input logic [DESC_WORDS*WORD_W-1:0] w, input int idx);
    return w[idx*WORD_W +: WORD_W];
  endfunction

  function automatic desc_t decode_desc(input logic [DESC_WORDS*WORD_W-1:0] w);
    desc_t d;
    logic [31:0] lo;
    lo         = pick_word(w, W_LINK_LO);
    d.bus_addr = {pick_word(w, W_BUS_HI), pick_word(w, W_BUS_LO)};
    d.count    = pick_word(w, W_COUNT);
    d.last     = lo[LINK_LAST_BIT];
    d.irq      = lo[LINK_IRQ_BIT];
    d.to_host  = lo[LINK_DIR_BIT];
    d.next_ptr = align_ptr(pick_word(w, W_LINK_HI), lo);
    return d;
  endfunction

  function automatic logic launch_cmd(input logic [31:0] w);
    return w[CS_ENABLE] & w[CS_START] & w[CS_SGMODE];
  endfunction

endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
  import sgdma_pkg::*;
#(
  parameter int OFF_W   = 2,
  parameter int BYTES_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [OFF_W-1:0] reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             busy,
  input  logic             chain_end,
  input  logic             xfer_complete,
  input  logic [31:0]      xfer_len,
  input  logic             irq_event,
  output logic             launch,
  output logic [63:0]      head_ptr,
  output logic             abort_pend,
  output logic             irq
);

  localparam logic [OFF_W-1:0] OFF_PTR_LO = OFF_W'(0);
  localparam logic [OFF_W-1:0] OFF_PTR_HI = OFF_W'(1);
  localparam logic [OFF_W-1:0] OFF_CTRL   = OFF_W'(2);
  localparam logic [OFF_W-1:0] OFF_BYTES  = OFF_W'(3);

  logic [31:0]        ptr_lo_q, ptr_hi_q;
  logic               en_q, sg_q, irqf_q, abort_q, irq_q;
  logic [BYTES_W-1:0] bytes_q;
  logic               ctrl_wr;
  logic [31:0]        status_word;
  logic [31:0]        rd_mux;

  assign ctrl_wr  = reg_wr && (reg_addr == OFF_CTRL);
  assign launch   = ctrl_wr && launch_cmd(reg_wdata) && !busy;
  assign head_ptr = align_ptr(ptr_hi_q, ptr_lo_q);
  assign abort_pend = abort_q;
  assign irq      = irq_q;

  always_comb begin
    status_word            = '0;
    status_word[CS_ENABLE] = en_q;
    status_word[CS_ABORT]  = abort_q;
    status_word[CS_DONE]   = !busy;
    status_word[CS_IRQF]   = irqf_q;
    status_word[CS_SGMODE] = sg_q;
  end

  always_comb begin
    case (reg_addr)
      OFF_PTR_LO: rd_mux = ptr_lo_q;
      OFF_PTR_HI: rd_mux = ptr_hi_q;
      OFF_CTRL:   rd_mux = status_word;
      default:    rd_mux = 32'(bytes_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_lo_q  <= '0;
      ptr_hi_q  <= '0;
      en_q      <= 1'b0;
      sg_q      <= 1'b0;
      irqf_q    <= 1'b0;
      abort_q   <= 1'b0;
      irq_q     <= 1'b0;
      bytes_q   <= '0;
      reg_rdata <= '0;
    end else begin
      irq_q <= irq_event;
      if (reg_wr && reg_addr == OFF_PTR_LO) ptr_lo_q <= reg_wdata;
      if (reg_wr && reg_addr == OFF_PTR_HI) ptr_hi_q <= reg_wdata;
      if (ctrl_wr) begin
        en_q <= reg_wdata[CS_ENABLE];
        sg_q <= reg_wdata[CS_SGMODE];
      end
      // flag: a new event wins over a clear in the same cycle
      if (irq_event) irqf_q <= 1'b1;
      else if (ctrl_wr && reg_wdata[CS_IRQF]) irqf_q <= 1'b0;
      // abort request only means something while a chain runs
      if (chain_end || launch) abort_q <= 1'b0;
      else if (ctrl_wr && reg_wdata[CS_ABORT] && busy) abort_q <= 1'b1;
      if (launch) bytes_q <= '0;
      else if (xfer_complete) bytes_q <= bytes_q + BYTES_W'(xfer_len);
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/sgdma_fetch.sv
module sgdma_fetch
  import sgdma_pkg::*;
#(
  parameter int WORDS = DESC_WORDS
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [63:0] base,
  output logic        rd_req,
  output logic [63:0] rd_addr,
  input  logic        rd_ack,
  input  logic [31:0] rd_data,
  output desc_t       desc_out,
  output logic        desc_valid
);

  localparam int IDX_W = $clog2(WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  logic             active;
  logic [IDX_W-1:0] idx;
  logic [31:0]      words [WORDS];
  logic [WORDS*32-1:0] packed_words;
  logic             word_taken;

  assign word_taken = active && rd_ack;
  assign rd_req     = active;
  assign rd_addr    = base + 64'({idx, 2'b00});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      idx        <= '0;
      desc_valid <= 1'b0;
    end else begin
      desc_valid <= 1'b0;
      if (go) begin
        active <= 1'b1;
        idx    <= '0;
      end else if (word_taken) begin
        if (idx == LAST_IDX) begin
          active     <= 1'b0;
          desc_valid <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) words[g] <= '0;
      else if (word_taken && idx == IDX_W'(g)) words[g] <= rd_data;
    end
    assign packed_words[g*32 +: 32] = words[g];
  end

  assign desc_out = decode_desc(packed_words);

endmodule

// File: rtl/sgdma_seq.sv
module sgdma_seq
  import sgdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch,
  input  logic [63:0] head_ptr,
  input  logic        abort_pend,
  input  desc_t       desc,
  input  logic        desc_valid,
  input  logic        xfer_done,
  output logic        go,
  output logic [63:0] cur_ptr,
  output logic        xfer_valid,
  output logic [63:0] xfer_addr,
  output logic [31:0] xfer_len,
  output logic        xfer_to_host,
  output logic        busy,
  output logic        xfer_complete,
  output logic        chain_end,
  output logic        irq_event
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_XFER} state_t;
  state_t state;

  logic bad_desc;
  logic fetch_stop;
  logic xfer_stop;

  assign busy          = (state != S_IDLE);
  assign xfer_valid    = (state == S_XFER);
  assign xfer_addr     = desc.bus_addr;
  assign xfer_len      = desc.count;
  assign xfer_to_host  = desc.to_host;
  assign xfer_complete = (state == S_XFER) && xfer_done;
  assign irq_event     = xfer_complete && desc.irq;

  assign bad_desc   = (desc.bus_addr == 64'd0);
  assign fetch_stop = (state == S_FETCH) && desc_valid && (abort_pend || bad_desc);
  assign xfer_stop  = xfer_complete && (desc.last || abort_pend);
  assign chain_end  = fetch_stop || xfer_stop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      go      <= 1'b0;
      cur_ptr <= '0;
    end else begin
      go <= 1'b0;
      case (state)
        S_IDLE: begin
          if (launch) begin
            cur_ptr <= head_ptr;
            go      <= 1'b1;
            state   <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (desc_valid) state <= fetch_stop ? S_IDLE : S_XFER;
        end
        S_XFER: begin
          if (xfer_done) begin
            if (xfer_stop) begin
              state <= S_IDLE;
            end else begin
              cur_ptr <= desc.next_ptr;
              go      <= 1'b1;
              state   <= S_FETCH;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
  import sgdma_pkg::*;
#(
  parameter int OFF_W   = 2,
  parameter int BYTES_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [OFF_W-1:0] reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             fetch_req,
  output logic [63:0]      fetch_addr,
  input  logic             fetch_ack,
  input  logic [31:0]      fetch_data,
  output logic             xfer_valid,
  output logic [63:0]      xfer_addr,
  output logic [31:0]      xfer_len,
  output logic             xfer_to_host,
  input  logic             xfer_done,
  output logic             irq
);

  // named internal events, visible to the checker
  logic        launch;
  logic        chain_busy;
  logic        chain_end;
  logic        xfer_complete;
  logic        irq_event;
  logic        abort_pend;
  logic        desc_loaded;
  logic        fetch_go;
  logic [63:0] head_ptr;
  logic [63:0] cur_ptr;
  desc_t       desc;

  sgdma_regs #(.OFF_W(OFF_W), .BYTES_W(BYTES_W)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .busy          (chain_busy),
    .chain_end     (chain_end),
    .xfer_complete (xfer_complete),
    .xfer_len      (xfer_len),
    .irq_event     (irq_event),
    .launch        (launch),
    .head_ptr      (head_ptr),
    .abort_pend    (abort_pend),
    .irq           (irq)
  );

  sgdma_fetch #(.WORDS(DESC_WORDS)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (fetch_go),
    .base       (cur_ptr),
    .rd_req     (fetch_req),
    .rd_addr    (fetch_addr),
    .rd_ack     (fetch_ack),
    .rd_data    (fetch_data),
    .desc_out   (desc),
    .desc_valid (desc_loaded)
  );

  sgdma_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .launch        (launch),
    .head_ptr      (head_ptr),
    .abort_pend    (abort_pend),
    .desc          (desc),
    .desc_valid    (desc_loaded),
    .xfer_done     (xfer_done),
    .go            (fetch_go),
    .cur_ptr       (cur_ptr),
    .xfer_valid    (xfer_valid),
    .xfer_addr     (xfer_addr),
    .xfer_len      (xfer_len),
    .xfer_to_host  (xfer_to_host),
    .busy          (chain_busy),
    .xfer_complete (xfer_complete),
    .chain_end     (chain_end),
    .irq_event     (irq_event)
  );

endmodule

// File: rtl/sgdma_checker.sv
module sgdma_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        fetch_req,
  input logic        fetch_ack,
  input logic [63:0] fetch_addr,
  input logic        xfer_valid,
  input logic        xfer_done,
  input logic [63:0] xfer_addr,
  input logic [31:0] xfer_len,
  input logic        irq,
  input logic        chain_busy,
  input logic        chain_end
);

  assert_fetch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !fetch_ack |=> fetch_req && $stable(fetch_addr));

  assert_fetch_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> fetch_addr[1:0] == 2'b00);

  assert_xfer_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_done |=> xfer_valid && $stable(xfer_addr) && $stable(xfer_len));

  assert_one_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_req && xfer_valid));

  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_busy |-> !fetch_req && !xfer_valid);

  assert_end_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chain_end |=> !chain_busy);

  assert_busy_until_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chain_busy && !chain_end |=> chain_busy);

  assert_no_zero_xfer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> xfer_addr != 64'd0);

endmodule

bind sgdma_engine sgdma_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fetch_req  (fetch_req),
  .fetch_ack  (fetch_ack),
  .fetch_addr (fetch_addr),
  .xfer_valid (xfer_valid),
  .xfer_done  (xfer_done),
  .xfer_addr  (xfer_addr),
  .xfer_len   (xfer_len),
  .irq        (irq),
  .chain_busy (chain_busy),
  .chain_end  (chain_end)
);

// File: tb/sim_sgdma_engine.sv
module sim_sgdma_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fetch_req, fetch_ack = 1'b0;
  logic [63:0] fetch_addr;
  logic [31:0] fetch_data = '0;
  logic        xfer_valid, xfer_to_host, xfer_done = 1'b0, irq;
  logic [63:0] xfer_addr;
  logic [31:0] xfer_len;

  always #5 clk = ~clk;

  sgdma_engine u0 (.*);

  int total = 0, fails = 0, cyc = 0;
  bit finished = 0;

  // host memory model: 32 descriptor slots of 8 words
  logic [31:0] mem [256];

  // responder logs
  logic [63:0] flog [256];
  int fn = 0, fcnt = 0, flat = 0;
  logic [63:0] xa [64];
  logic [31:0] xl [64];
  logic        xd [64];
  int xn = 0, xcnt = 0, xlat = 0, irqn = 0;

  // expected chain
  logic [63:0] ea [64];
  logic [31:0] el [64];
  logic        ed [64];
  int en = 0, eirq = 0;
  logic [31:0] esum;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (fetch_ack) fetch_ack = 1'b0;
    else if (fetch_req) begin
      if (fcnt == 0) begin
        fetch_ack  = 1'b1;
        fetch_data = mem[fetch_addr[9:2]];
        flog[fn % 256] = fetch_addr;
        fn++;
        fcnt = flat + int'($urandom % 3);
      end else fcnt--;
    end
    if (xfer_done) xfer_done = 1'b0;
    else if (xfer_valid) begin
      if (xcnt == 0) begin
        xfer_done = 1'b1;
        if (xn < 64) begin xa[xn] = xfer_addr; xl[xn] = xfer_len; xd[xn] = xfer_to_host; end
        xn++;
        xcnt = xlat + int'($urandom % 3);
      end else xcnt--;
    end
    if (irq) irqn++;
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_done(output bit ok);
    logic [31:0] s;
    ok = 0;
    for (int i = 0; i < 6000; i++) begin
      rd(2'd2, s);
      if (s[4]) begin ok = 1; break; end
    end
  endtask

  task automatic put_desc(input int slot, input logic [63:0] a, input logic [31:0] len,
                          input int link, input logic [4:0] flags);
    mem[slot*8+0] = a[31:0];
    mem[slot*8+1] = a[63:32];
    mem[slot*8+2] = $urandom;
    mem[slot*8+3] = 32'd0;
    mem[slot*8+4] = len;
    mem[slot*8+5] = 32'd0;
    mem[slot*8+6] = (32'(link) << 5) | 32'(flags);
    mem[slot*8+7] = 32'd0;
  endtask

  // bench model of the walk: valid address -> transfer; bit1 ends; link by slot
  task automatic walk(input int head);
    int s;
    s = head; en = 0; eirq = 0; esum = 0;
    for (int k = 0; k < 40; k++) begin
      if ({mem[s*8+1], mem[s*8+0]} == 64'd0) break;
      ea[en] = {mem[s*8+1], mem[s*8+0]};
      el[en] = mem[s*8+4];
      ed[en] = mem[s*8+6][3];
      esum   = esum + mem[s*8+4];
      if (mem[s*8+6][2]) eirq++;
      en++;
      if (mem[s*8+6][1]) break;
      s = int'(mem[s*8+6][9:5]);
    end
  endtask

  task automatic clear_logs();
    fn = 0; xn = 0; irqn = 0;
  endtask

  task automatic launch(input int head);
    wr(2'd0, (32'(head) << 5) | 32'h13);
    wr(2'd1, 32'd0);
    wr(2'd2, 32'h0000_0103);
  endtask

  task automatic run_and_compare(input int head, input string tag);
    bit ok;
    logic [31:0] s;
    clear_logs();
    walk(head);
    launch(head);
    wait_done(ok);
    check(ok, {tag, " R5 done"}, 64'(ok), 1);
    check(xn == en, {tag, " R3 transfer count"}, 64'(xn), 64'(en));
    for (int i = 0; i < en && i < xn; i++) begin
      check(xa[i] == ea[i], {tag, " R3/R4 xfer_addr"}, xa[i], ea[i]);
      check(xl[i] == el[i], {tag, " R3 xfer_len"}, 64'(xl[i]), 64'(el[i]));
      check(xd[i] == ed[i], {tag, " R3 xfer_to_host"}, 64'(xd[i]), 64'(ed[i]));
    end
    rd(2'd3, s);
    check(s == esum, {tag, " R7 byte total"}, 64'(s), 64'(esum));
    check(irqn == eirq, {tag, " R6 irq pulses"}, 64'(irqn), 64'(eirq));
    rd(2'd2, s);
    check(s[5] == (eirq > 0), {tag, " R6 flag"}, 64'(s[5]), 64'(eirq > 0));
    wr(2'd2, 32'h20);
    rd(2'd2, s);
    check(s[5] == 1'b0, {tag, " R6 flag cleared"}, 64'(s[5]), 0);
  endtask

  function automatic logic [63:0] rand_addr();
    return {32'($urandom % 4), ($urandom & 32'hFFFF_FFFC) | 32'h4};
  endfunction

  initial begin
    logic [31:0] s;
    bit ok;
    int n0, n1, f0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check(!fetch_req && !xfer_valid, "R1 no requests", 64'({fetch_req, xfer_valid}), 0);
    rd(2'd2, s);
    check(s[4] == 1'b1, "R1 done after reset", 64'(s[4]), 1);
    check(s[5] == 1'b0, "R1 flag after reset", 64'(s[5]), 0);
    rd(2'd3, s);
    check(s == 0, "R1 byte total after reset", 64'(s), 0);

    // R12: incomplete launch words
    put_desc(3, rand_addr(), 32'd64, 4, 5'b00110);
    clear_logs();
    wr(2'd0, 32'd3 << 5); wr(2'd1, 0);
    wr(2'd2, 32'h0000_0003);
    wr(2'd2, 32'h0000_0102);
    wr(2'd2, 32'h0000_0101);
    repeat (20) @(negedge clk);
    check(fn == 0, "R12 no fetch without all launch bits", 64'(fn), 0);

    // R2 ordering + R3/R4/R5/R6/R7: directed two-descriptor chain
    put_desc(3, rand_addr(), 32'd128, 9, 5'b01000);
    put_desc(9, rand_addr(), 32'd36, 0, 5'b00110);
    flat = 0; xlat = 1;
    run_and_compare(3, "directed");
    for (int i = 0; i < 8; i++)
      check(flog[i] == 64'(3*32 + 4*i), "R2 word order", flog[i], 64'(3*32 + 4*i));

    // R10: zero bus address ends the chain
    put_desc(5, rand_addr(), 32'd40, 6, 5'b00000);
    put_desc(6, 64'd0, 32'd80, 7, 5'b00000);
    put_desc(7, rand_addr(), 32'd8, 0, 5'b00010);
    run_and_compare(5, "R10 zero address");
    check(xn == 1, "R10 single transfer", 64'(xn), 1);

    // R8: launch while busy is ignored
    put_desc(10, rand_addr(), 32'd100, 11, 5'b00000);
    put_desc(11, rand_addr(), 32'd200, 0, 5'b00010);
    put_desc(12, rand_addr(), 32'd300, 0, 5'b00010);
    xlat = 30;
    clear_logs();
    walk(10);
    launch(10);
    repeat (15) @(negedge clk);
    wr(2'd0, 32'd12 << 5);
    wr(2'd2, 32'h0000_0103);
    wait_done(ok);
    check(xn == en, "R8 transfer count unchanged", 64'(xn), 64'(en));
    check(xa[0] == ea[0] && xa[1] == ea[1], "R8 chain unchanged", xa[1], ea[1]);
    rd(2'd3, s);
    check(s == esum, "R8 byte total not cleared", 64'(s), 64'(esum));

    // R9: abort during the first fetch
    xlat = 1; flat = 12;
    clear_logs();
    launch(10);
    repeat (3) @(negedge clk);
    wr(2'd2, 32'h0000_0004);
    wait_done(ok);
    check(ok, "R9 done after abort in fetch", 64'(ok), 1);
    check(xn == 0, "R9 no transfer after abort in fetch", 64'(xn), 0);
    rd(2'd3, s);
    check(s == 0, "R9 R7 byte total cleared on launch", 64'(s), 0);

    // R11 + R9: looping chain, aborted
    put_desc(20, rand_addr(), 32'd16, 21, 5'b01000);
    put_desc(21, rand_addr(), 32'd24, 20, 5'b00100);
    flat = 0; xlat = 2;
    clear_logs();
    launch(20);
    for (int i = 0; i < 20000 && xn < 7; i++) @(negedge clk);
    check(xn >= 7, "R11 loop keeps running", 64'(xn), 7);
    wr(2'd2, 32'h0000_0004);
    n0 = xn;
    wait_done(ok);
    n1 = xn;
    check(ok && (n1 - n0) <= 1, "R9 loop stops after current transfer", 64'(n1 - n0), 1);
    for (int i = 0; i < n1 && i < 64; i++)
      check(xa[i] == {mem[(i%2==0 ? 20 : 21)*8+1], mem[(i%2==0 ? 20 : 21)*8]}, "R11 loop order",
            xa[i], {mem[(i%2==0 ? 20 : 21)*8+1], mem[(i%2==0 ? 20 : 21)*8]});
    check(irqn == n1 / 2, "R6 loop irq count", 64'(irqn), 64'(n1 / 2));
    f0 = fn;
    repeat (40) @(negedge clk);
    check(fn == f0 && !fetch_req, "R9 no fetch after abort", 64'(fn), 64'(f0));
    wr(2'd2, 32'h20);

    // random chains
    for (int t = 0; t < 14; t++) begin
      int n, base, step, sl, nx;
      n = 1 + int'($urandom % 6);
      base = int'($urandom % 32);
      step = 2 * int'($urandom % 8) + 1;
      flat = int'($urandom % 3);
      xlat = int'($urandom % 4);
      for (int i = 0; i < n; i++) begin
        sl = (base + i * step) % 32;
        nx = (base + (i + 1) * step) % 32;
        put_desc(sl, rand_addr(), ($urandom % 1024) * 4, nx,
                 {1'b0, 1'($urandom), 1'($urandom), (i == n - 1), 1'($urandom)});
      end
      run_and_compare(base, "random R4");
    end

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule